// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit Accumulator CPU

This unit turns an addressing-mode code and the operand bytes that follow an opcode into the 16-bit memory address that the instruction will use. It is given the X and Y index registers and the address of the instruction that follows, the value a branch needs. The unit answers directly for register-free, page-zero, full-range, indexed and branch-relative modes. For the three pointer modes it fetches a two-byte pointer through its own byte-wide read port before it answers.

The instruction sequencer raises `start` for one cycle while the unit is idle, with the mode and operand inputs valid in that cycle. It then waits for `done`. When `done` is high, `eff_addr` holds the result. `addr_valid` tells whether that result names a memory location at all: it is low for modes whose operand is the accumulator or a constant byte. The read port expects a synchronous memory: the data for an address presented with `mem_rd` high appears on `mem_rdata` one clock later.

Top module: `ea_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `mem_rd` and `addr_valid` are 0.
- R2: Page-zero mode (code 2) yields {0x00, op_lo}. `done` is high in the cycle right after the accepting clock edge for every mode that needs no pointer read.
- R3: Page-zero-indexed modes (code 3 with X, code 4 with Y) yield {0x00, (op_lo + index) mod 256}, so the high byte is always 0x00.
- R4: Full-range mode (code 5) yields {op_hi, op_lo}. Indexed full-range modes (code 6 with X, code 7 with Y) add the index to it modulo 65536.
- R5: Branch-relative mode (code 8) yields (pc_next + op_lo sign-extended to 16 bits) mod 65536, where pc_next is the address of the instruction after the branch.
- R6: Accumulator mode (code 0), constant mode (code 1) and the unused codes 12 to 15 finish like R2, with `addr_valid` 0, `eff_addr` 0x0000 and no memory read.
- R7: Pointer mode (code 9) reads pointer P = {op_hi, op_lo} and then (P + 1) mod 65536, and yields {byte at P+1, byte at P}. `done` rises in the third cycle after the accepting edge's following cycle, four clock edges after acceptance.
- R8: Pre-indexed pointer mode (code 10) uses Z = (op_lo + X) mod 256 and reads addresses {0x00, Z} and then {0x00, (Z + 1) mod 256}. The result is the pointer so formed.
- R9: Post-indexed pointer mode (code 11) reads {0x00, op_lo} and then {0x00, (op_lo + 1) mod 256}, and yields (pointer + Y) mod 65536.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. `done` lasts one cycle. `start` is ignored while `busy` is high. `eff_addr` and `addr_valid` hold their value until the next accepted `start`.
- R11: `mem_rd` is high only in the two cycles right after acceptance of a pointer mode. The first cycle presents the low-byte pointer address and the second the high-byte address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one address calculation (taken only when idle) |
| mode | input | 4 | Addressing-mode code |
| op_lo | input | 8 | First operand byte after the opcode |
| op_hi | input | 8 | Second operand byte (full-range and pointer modes) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc_next | input | 16 | Address of the instruction following this one |
| mem_rd | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer read address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| busy | output | 1 | Calculation in progress or result being presented |
| done | output | 1 | One-cycle strobe: result ready |
| addr_valid | output | 1 | Result is a memory address |
| eff_addr | output | 16 | Effective address |

## Verification
The bench uses the package's 16-bit address and 8-bit data widths, the only widths the block has. At those widths the carry and wrap edges are all reachable with small operands: page-zero sums past 0xFF, full-range sums past 0xFFFF, backward and wrapping branches, a pointer at 0xFFFF, and page-zero pointers at 0xFF. The bench's memory returns a byte computed from each address, so every pointer read gives a distinct value that the reference model predicts. Requests that are held or altered during a calculation show that a busy unit keeps its result.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int PAGE_BITS = AW - DW;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;

    typedef enum logic [3:0] {
        AM_ACC  = 4'd0,
        AM_IMM  = 4'd1,
        AM_ZP   = 4'd2,
        AM_ZPX  = 4'd3,
        AM_ZPY  = 4'd4,
        AM_ABS  = 4'd5,
        AM_ABSX = 4'd6,
        AM_ABSY = 4'd7,
        AM_REL  = 4'd8,
        AM_IND  = 4'd9,
        AM_INDX = 4'd10,
        AM_INDY = 4'd11
    } mode_e;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_LO,
        PS_HI,
        PS_WAIT
    } pstate_e;

    // Where the two pointer bytes come from, and what is added afterwards.
    typedef struct packed {
        addr_t first;
        addr_t second;
        byte_t post_add;
        logic  in_page0;
    } ptr_plan_t;

    function automatic addr_t page0(input byte_t b);
        return {{PAGE_BITS{1'b0}}, b};
    endfunction

    function automatic addr_t sext(input byte_t b);
        return {{PAGE_BITS{b[DW-1]}}, b};
    endfunction

    function automatic logic needs_ptr(input logic [3:0] m);
        return (m == AM_IND) || (m == AM_INDX) || (m == AM_INDY);
    endfunction

    function automatic ptr_plan_t plan_ptr(input logic [3:0] m, input byte_t lo,
                                           input byte_t hi, input byte_t x,
                                           input byte_t y);
        ptr_plan_t p;
        byte_t     z;
        p = '0;
        z = '0;
        case (m)
            AM_IND: begin
                p.first  = {hi, lo};
                p.second = addr_t'({hi, lo} + addr_t'(1));
            end
            AM_INDX: begin
                z          = byte_t'(lo + x);
                p.first    = page0(z);
                p.second   = page0(byte_t'(z + byte_t'(1)));
                p.in_page0 = 1'b1;
            end
            default: begin
                p.first    = page0(lo);
                p.second   = page0(byte_t'(lo + byte_t'(1)));
                p.post_add = y;
                p.in_page0 = 1'b1;
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ea_direct.sv
module ea_direct
    import ea_pkg::*;
(
    input  logic [3:0] mode,
    input  byte_t      op_lo,
    input  byte_t      op_hi,
    input  byte_t      idx_x,
    input  byte_t      idx_y,
    input  addr_t      pc_next,
    output addr_t      ea,
    output logic       has_addr,
    output logic       indirect
);

    addr_t full;
    assign full = {op_hi, op_lo};

    always_comb begin
        ea       = '0;
        has_addr = 1'b0;
        indirect = needs_ptr(mode);
        case (mode)
            AM_ZP: begin
                ea       = page0(op_lo);
                has_addr = 1'b1;
            end
            AM_ZPX: begin
                ea       = page0(byte_t'(op_lo + idx_x));
                has_addr = 1'b1;
            end
            AM_ZPY: begin
                ea       = page0(byte_t'(op_lo + idx_y));
                has_addr = 1'b1;
            end
            AM_ABS: begin
                ea       = full;
                has_addr = 1'b1;
            end
            AM_ABSX: begin
                ea       = addr_t'(full + page0(idx_x));
                has_addr = 1'b1;
            end
            AM_ABSY: begin
                ea       = addr_t'(full + page0(idx_y));
                has_addr = 1'b1;
            end
            AM_REL: begin
                ea       = addr_t'(pc_next + sext(op_lo));
                has_addr = 1'b1;
            end
            default: begin
                ea       = '0;
                has_addr = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ea_ptr_seq.sv
module ea_ptr_seq
    import ea_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       launch,
    input  logic [3:0] mode,
    input  byte_t      op_lo,
    input  byte_t      op_hi,
    input  byte_t      idx_x,
    input  byte_t      idx_y,
    input  byte_t      rdata,
    output logic       rd,
    output addr_t      rd_addr,
    output logic       fin,
    output addr_t      result,
    output logic       active
);

    pstate_e   state_q;
    ptr_plan_t plan_q;
    byte_t     lo_byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
        end else begin
            case (state_q)
                PS_IDLE: if (launch) state_q <= PS_LO;
                PS_LO:   state_q <= PS_HI;
                PS_HI:   state_q <= PS_WAIT;
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == PS_IDLE && launch) begin
            plan_q <= plan_ptr(mode, op_lo, op_hi, idx_x, idx_y);
        end
        if (state_q == PS_HI) begin
            lo_byte_q <= rdata;
        end
    end

    assign rd      = (state_q == PS_LO) || (state_q == PS_HI);
    assign rd_addr = (state_q == PS_HI) ? plan_q.second : plan_q.first;
    assign fin     = (state_q == PS_WAIT);
    assign active  = (state_q != PS_IDLE);
    assign result  = addr_t'({rdata, lo_byte_q} + page0(plan_q.post_add));

    AST_PTR_IN_PAGE0: assert property (@(posedge clk) disable iff (rst)
        (rd && plan_q.in_page0) |-> (rd_addr[AW-1:DW] == '0)); // R8

    AST_PTR_NEXT_BYTE: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_HI) |-> (rd_addr[DW-1:0] == byte_t'($past(rd_addr[DW-1:0]) + byte_t'(1)))); // R7

    AST_NO_READ_AT_FIN: assert property (@(posedge clk) disable iff (rst)
        fin |-> !rd); // R11

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  mode,
    input  logic [7:0]  op_lo,
    input  logic [7:0]  op_hi,
    input  logic [7:0]  idx_x,
    input  logic [7:0]  idx_y,
    input  logic [15:0] pc_next,
    output logic        mem_rd,
    output logic [15:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic        addr_valid,
    output logic [15:0] eff_addr
);

    addr_t      dir_ea;
    logic       dir_has;
    logic       dir_ind;
    addr_t      seq_result;
    logic       seq_fin;
    logic       seq_active;
    logic       done_q;
    logic       valid_q;
    addr_t      ea_q;
    logic [3:0] mode_q;
    logic       accept;
    logic       launch;

    assign accept = start && !seq_active && !done_q;
    assign launch = accept && dir_ind;

    ea_direct u_direct (
        .mode     (mode),
        .op_lo    (op_lo),
        .op_hi    (op_hi),
        .idx_x    (idx_x),
        .idx_y    (idx_y),
        .pc_next  (pc_next),
        .ea       (dir_ea),
        .has_addr (dir_has),
        .indirect (dir_ind)
    );

    ea_ptr_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .mode    (mode),
        .op_lo   (op_lo),
        .op_hi   (op_hi),
        .idx_x   (idx_x),
        .idx_y   (idx_y),
        .rdata   (mem_rdata),
        .rd      (mem_rd),
        .rd_addr (mem_addr),
        .fin     (seq_fin),
        .result  (seq_result),
        .active  (seq_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            valid_q <= 1'b0;
            ea_q    <= '0;
            mode_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                mode_q <= mode;
            end
            if (accept && !dir_ind) begin
                done_q  <= 1'b1;
                ea_q    <= dir_ea;
                valid_q <= dir_has;
            end else if (seq_fin) begin
                done_q  <= 1'b1;
                ea_q    <= seq_result;
                valid_q <= 1'b1;
            end
        end
    end

    assign done       = done_q;
    assign busy       = seq_active || done_q;
    assign addr_valid = valid_q;
    assign eff_addr   = ea_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R10

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(eff_addr) && $stable(addr_valid))); // R10

    AST_NO_ADDR_MODES: assert property (@(posedge clk) disable iff (rst)
        (done && (mode_q == AM_ACC || mode_q == AM_IMM)) |-> !addr_valid); // R6

    AST_PAGE0_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY))
            |-> (eff_addr[15:8] == 8'h00)); // R3

    AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (busy && !done)); // R11

endmodule

// File: tb/ea_gen_tb.sv
module ea_gen_tb_top;

    localparam time CLK_PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  op_lo = '0;
    logic [7:0]  op_hi = '0;
    logic [7:0]  idx_x = '0;
    logic [7:0]  idx_y = '0;
    logic [15:0] pc_next = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        busy;
    logic        done;
    logic        addr_valid;
    logic [15:0] eff_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_gen dut_i (
        .clk (clk), .rst (rst), .start (start), .mode (mode),
        .op_lo (op_lo), .op_hi (op_hi), .idx_x (idx_x), .idx_y (idx_y),
        .pc_next (pc_next), .mem_rd (mem_rd), .mem_addr (mem_addr),
        .mem_rdata (mem_rdata), .busy (busy), .done (done),
        .addr_valid (addr_valid), .eff_addr (eff_addr)
    );

    // Memory contents: a byte derived from each address.
    function automatic logic [7:0] mb(input logic [15:0] a);
        return (a[7:0] ^ {a[14:8], a[15]}) + 8'h3C;
    endfunction

    always_ff @(posedge clk) mem_rdata <= mb(mem_addr);

    function automatic int sx(input logic [7:0] b);
        return (b >= 8'd128) ? int'(b) - 256 : int'(b);
    endfunction

    function automatic int ptr_first(input logic [3:0] m, input logic [7:0] lo,
                                     input logic [7:0] hi, input logic [7:0] x);
        if (m == 4'd9)  return int'(hi) * 256 + int'(lo);
        if (m == 4'd10) return (int'(lo) + int'(x)) % 256;
        return int'(lo);
    endfunction

    function automatic int ptr_second(input logic [3:0] m, input logic [7:0] lo,
                                      input logic [7:0] hi, input logic [7:0] x);
        if (m == 4'd9) return (ptr_first(m, lo, hi, x) + 1) % 65536;
        return (ptr_first(m, lo, hi, x) + 1) % 256;
    endfunction

    function automatic int expect_ea(input logic [3:0] m, input logic [7:0] lo,
                                     input logic [7:0] hi, input logic [7:0] x,
                                     input logic [7:0] y, input logic [15:0] pc);
        int full = int'(hi) * 256 + int'(lo);
        int p;
        case (m)
            4'd2: return int'(lo);
            4'd3: return (int'(lo) + int'(x)) % 256;
            4'd4: return (int'(lo) + int'(y)) % 256;
            4'd5: return full;
            4'd6: return (full + int'(x)) % 65536;
            4'd7: return (full + int'(y)) % 65536;
            4'd8: return (int'(pc) + sx(lo) + 65536) % 65536;
            4'd9, 4'd10, 4'd11: begin
                p = int'(mb(16'(ptr_first(m, lo, hi, x))))
                  + 256 * int'(mb(16'(ptr_second(m, lo, hi, x))));
                if (m == 4'd11) p = (p + int'(y)) % 65536;
                return p;
            end
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One request; the reference is compared on every clock until one cycle after done.
    task automatic run(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc,
                       input string tag, input bit hold);
        bit ind = (m == 4'd9) || (m == 4'd10) || (m == 4'd11);
        bit has = (m >= 4'd2) && (m <= 4'd11);
        int lat = ind ? 4 : 1;
        int ea  = expect_ea(m, lo, hi, x, y, pc);
        int a1  = ptr_first(m, lo, hi, x);
        int a2  = ptr_second(m, lo, hi, x);
        @(negedge clk);
        mode = m; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; pc_next = pc;
        start = 1'b1;
        @(posedge clk);
        for (int n = 1; n <= lat + 1; n++) begin
            @(negedge clk);
            chk(busy == (n <= lat), "R10 busy", int'(busy), int'(n <= lat));
            chk(done == (n == lat), "R10 done", int'(done), int'(n == lat));
            chk(mem_rd == (ind && n <= 2), "R11 mem_rd", int'(mem_rd), int'(ind && n <= 2));
            if (ind && n == 1) chk(int'(mem_addr) == a1, "R11 first ptr addr", int'(mem_addr), a1);
            if (ind && n == 2) chk(int'(mem_addr) == a2, "R11 second ptr addr", int'(mem_addr), a2);
            if (n >= lat) begin
                chk(int'(eff_addr) == ea, tag, int'(eff_addr), ea);
                chk(addr_valid == has, {tag, " valid"}, int'(addr_valid), int'(has));
            end
            if (hold && n <= lat) begin
                mode = 4'd5; op_lo = ~lo; op_hi = ~hi; idx_x = x + 8'd7;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_rd && !addr_valid, "R1 during reset",
            int'({busy, done, mem_rd, addr_valid}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_rd && !addr_valid, "R1 after reset",
            int'({busy, done, mem_rd, addr_valid}), 0);

        run(4'd2,  8'h7E, 8'h00, 8'h00, 8'h00, 16'h0000, "R2 page zero", 1'b0);
        run(4'd3,  8'h10, 8'h00, 8'h05, 8'h00, 16'h0000, "R3 page zero + X", 1'b0);
        run(4'd3,  8'hF0, 8'h00, 8'h20, 8'h00, 16'h0000, "R3 page zero + X wrap", 1'b0);
        run(4'd4,  8'hFF, 8'h00, 8'h00, 8'h01, 16'h0000, "R3 page zero + Y wrap", 1'b0);
        run(4'd5,  8'h34, 8'h12, 8'h00, 8'h00, 16'h0000, "R4 full range", 1'b0);
        run(4'd6,  8'hF0, 8'h12, 8'h20, 8'h00, 16'h0000, "R4 full + X page carry", 1'b0);
        run(4'd6,  8'hF0, 8'hFF, 8'h20, 8'h00, 16'h0000, "R4 full + X wrap", 1'b0);
        run(4'd7,  8'h00, 8'h80, 8'h00, 8'hFF, 16'h0000, "R4 full + Y", 1'b0);
        run(4'd8,  8'h10, 8'h00, 8'h00, 8'h00, 16'h0200, "R5 branch forward", 1'b0);
        run(4'd8,  8'h80, 8'h00, 8'h00, 8'h00, 16'h0200, "R5 branch backward", 1'b0);
        run(4'd8,  8'h20, 8'h00, 8'h00, 8'h00, 16'hFFF0, "R5 branch wrap high", 1'b0);
        run(4'd8,  8'hFE, 8'h00, 8'h00, 8'h00, 16'h0001, "R5 branch wrap low", 1'b0);
        run(4'd0,  8'h55, 8'h66, 8'h01, 8'h02, 16'h1234, "R6 accumulator", 1'b0);
        run(4'd1,  8'h55, 8'h66, 8'h01, 8'h02, 16'h1234, "R6 constant", 1'b0);
        run(4'd13, 8'h55, 8'h66, 8'h01, 8'h02, 16'h1234, "R6 unused code", 1'b0);
        run(4'd9,  8'h00, 8'h30, 8'h00, 8'h00, 16'h0000, "R7 pointer", 1'b0);
        run(4'd9,  8'hFF, 8'h30, 8'h00, 8'h00, 16'h0000, "R7 pointer page cross", 1'b0);
        run(4'd9,  8'hFF, 8'hFF, 8'h00, 8'h00, 16'h0000, "R7 pointer at top", 1'b0);
        run(4'd10, 8'h40, 8'h99, 8'h04, 8'h00, 16'h0000, "R8 pre-indexed", 1'b0);
        run(4'd10, 8'hF0, 8'h99, 8'h1F, 8'h00, 16'h0000, "R8 pre-indexed wrap", 1'b0);
        run(4'd10, 8'hFE, 8'h99, 8'h01, 8'h00, 16'h0000, "R8 pre-indexed ptr at FF", 1'b0);
        run(4'd11, 8'h20, 8'h99, 8'h00, 8'h03, 16'h0000, "R9 post-indexed", 1'b0);
        run(4'd11, 8'hFF, 8'h99, 8'h00, 8'hF0, 16'h0000, "R9 post-indexed ptr at FF", 1'b0);
        run(4'd9,  8'h10, 8'h40, 8'h00, 8'h00, 16'h0000, "R10 pointer start held", 1'b1);
        run(4'd3,  8'h08, 8'h00, 8'h02, 8'h00, 16'h0000, "R10 direct start held", 1'b1);
        run(4'd5,  8'hCD, 8'hAB, 8'h00, 8'h00, 16'h0000, "R10 after held", 1'b0);

        // R10: result is kept while idle with no start
        repeat (3) @(negedge clk);
        chk(eff_addr == 16'hABCD && addr_valid, "R10 result held", int'(eff_addr), 'hABCD);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule